// File: doc/BRIEF.md
# Paravirtual Device Legacy Register Header

This block is the device-side register header of a paravirtual I/O function in its legacy layout. A host driver reaches it through a simple synchronous register bus that carries a byte address, four byte enables, 32-bit write data and 32-bit read data. Read data comes out of a register one cycle after the read request. The header holds a fixed host feature word and a guest feature word. It also holds a bank of per-queue page-frame registers, which sit behind a queue-select index, and a read-only queue size. There is a notify doorbell, a device status byte and an interrupt status byte that clears when it is read.

The device logic behind the header gets a one-cycle notify strobe that carries the queue index, the live status byte, and the byte base address of every queue. It raises queue and configuration interrupt causes on two pulse inputs. When the message-interrupt option is built in, a configuration vector and a per-queue vector become visible in the dword after the status byte. The device-specific area then starts at byte 24 instead of byte 20. Accesses that fall in that area are passed to the device logic as an offset relative to the area's base.

Top module: `pvreg_legacy`

## Requirements
- R1: The dword at byte 0 reads the parameter HOST_FEAT on all lanes, and writes to it leave the value unchanged.
- R2: The guest feature dword at byte 4 resets to zero. Each write updates only the byte lanes whose enable is set.
- R3: The queue index is held in bits 31:16 of the dword at byte 12, and software can read and write it. The page-frame dword at byte 8 reads and writes the register of the queue that this index names. Output q_base for queue i carries that queue's page-frame value shifted left by 12 bits.
- R4: For an index below NUM_Q, the queue size in bits 15:0 of the dword at byte 12 reads 2**QSZ_LOG2. For an index at or above NUM_Q it reads zero, the page-frame dword reads zero, and writes to the page frame are dropped.
- R5: A write to the dword at byte 16 with byte enable 0 or 1 set raises notify_vld for exactly the following cycle, with notify_q equal to write data bits 15:0. A write to that dword with both of those enables clear produces no strobe. The doorbell field reads as zero.
- R6: The status byte is held in bits 23:16 of the dword at byte 16, driven onto dev_status, and written through byte enable 2. Writing zero to it clears the guest features, the queue index, every queue's page frame and every vector register.
- R7: The interrupt status byte is held in bits 31:24 of the dword at byte 16. A pulse on irq_queue sets bit 0, a pulse on irq_config sets bit 1, and intx is high while either bit is set.
- R8: A read of the dword at byte 16 with byte enable 3 set returns the interrupt status before clearing and then clears it. A cause that arrives in the same cycle as the read stays set afterwards.
- R9: With MSIX_EN set, bits 15:0 of the dword at byte 20 hold the configuration vector, and bits 31:16 hold the vector of the selected queue. Both are readable and writable per lane. They appear on cfg_vec and q_vec, where 0xFFFF means that no vector is assigned. With MSIX_EN clear, both outputs stay at 0xFFFF.
- R10: The device-specific area begins at byte 24 with MSIX_EN set and at byte 20 without it. An access at or above that base asserts dcfg_hit in the same cycle, presents dcfg_off as the byte offset from the base, and reads back dcfg_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the access |
| be | input | 4 | Byte lane enables |
| wr | input | 1 | Write request |
| rd | input | 1 | Read request |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd |
| dcfg_hit | output | 1 | Access falls in the device-specific area |
| dcfg_off | output | ADDR_W | Byte offset within the device-specific area |
| dcfg_rdata | input | 32 | Read data from the device-specific area |
| notify_vld | output | 1 | One-cycle doorbell strobe |
| notify_q | output | 16 | Queue index carried by the doorbell |
| dev_status | output | 8 | Current device status byte |
| q_base | output | NUM_Q*44 | Byte base address of each queue |
| cfg_vec | output | 16 | Configuration-change vector |
| q_vec | output | NUM_Q*16 | Vector of each queue |
| irq_queue | input | 1 | Queue interrupt cause pulse |
| irq_config | input | 1 | Configuration change cause pulse |
| intx | output | 1 | Level interrupt, high while any cause is pending |

## Verification
The bound checker watches five things on every cycle. The host feature word must come back on every read of byte 0. A doorbell strobe must trace back to a doorbell-lane write. An incoming queue cause must raise intx. A clean status read must drop intx. A zero status write must clear dev_status and every queue base. The per-lane merging of the writable words, the banking and out-of-range behaviour of the queue registers, a cause that arrives in the same cycle as the clearing read, the vector layout and the shifted device-specific base can only be shown by the bench's sweeps. Those sweeps run against a four-queue header built both with and without the vector option.

// File: rtl/pvreg_pkg.sv
package pvreg_pkg;
   // dword indices of the header (address bits above bit 1)
   localparam int DW_HFEAT  = 0;
   localparam int DW_GFEAT  = 1;
   localparam int DW_PFN    = 2;
   localparam int DW_QSZSEL = 3;
   localparam int DW_NTFY   = 4;
   localparam int DW_VEC    = 5;

   localparam int          PAGE_SHIFT  = 12;
   localparam int          QBASE_W     = 32 + PAGE_SHIFT;
   localparam logic [15:0] NO_VEC      = 16'hFFFF;
   localparam int          DCFG_LEGACY = 20;
   localparam int          DCFG_MSIX   = 24;

   typedef struct packed {
      logic hfeat;
      logic gfeat;
      logic pfn;
      logic qszsel;
      logic ntfy;
      logic vec;
      logic dcfg;
   } hit_t;

   function automatic logic [31:0] lane_merge(input logic [31:0] cur,
                                              input logic [31:0] nxt,
                                              input logic [3:0]  en);
      logic [31:0] res;
      for (int l = 0; l < 4; l++)
         res[l*8 +: 8] = en[l] ? nxt[l*8 +: 8] : cur[l*8 +: 8];
      return res;
   endfunction
endpackage

// File: rtl/pvreg_decode.sv
module pvreg_decode
   import pvreg_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter bit MSIX_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output hit_t              hit,
   output logic [ADDR_W-1:0] dcfg_off
);
   localparam int              DW_W = ADDR_W - 2;
   localparam int              BASE = MSIX_EN ? DCFG_MSIX : DCFG_LEGACY;
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

   logic [DW_W-1:0] dw;
   assign dw = addr[ADDR_W-1:2];

   always_comb begin
      hit        = '0;
      hit.dcfg   = (addr >= BASE_A);
      hit.hfeat  = (dw == DW_W'(DW_HFEAT));
      hit.gfeat  = (dw == DW_W'(DW_GFEAT));
      hit.pfn    = (dw == DW_W'(DW_PFN));
      hit.qszsel = (dw == DW_W'(DW_QSZSEL));
      hit.ntfy   = (dw == DW_W'(DW_NTFY));
      hit.vec    = MSIX_EN && (dw == DW_W'(DW_VEC));
   end

   assign dcfg_off = addr - BASE_A;
endmodule

// File: rtl/pvreg_isr.sv
module pvreg_isr (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_q,
   input  logic       set_c,
   input  logic       clr,
   output logic [7:0] isr
);
   logic [1:0] cause_r, cause_n;

   always_comb begin
      cause_n    = clr ? 2'b00 : cause_r;
      cause_n[0] = cause_n[0] | set_q;
      cause_n[1] = cause_n[1] | set_c;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cause_r <= 2'b00;
      else        cause_r <= cause_n;
   end

   assign isr = {6'b0, cause_r};
endmodule

// File: rtl/pvreg_qbank.sv
module pvreg_qbank
   import pvreg_pkg::*;
#(
   parameter int NUM_Q   = 4,
   parameter bit MSIX_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     dev_reset,
   input  logic [15:0]              sel,
   input  logic                     pfn_we,
   input  logic                     vec_we,
   input  logic [3:0]               be,
   input  logic [31:0]              wdata,
   output logic                     sel_valid,
   output logic [31:0]              sel_pfn,
   output logic [15:0]              sel_vec,
   output logic [NUM_Q*QBASE_W-1:0] q_base,
   output logic [NUM_Q*16-1:0]      q_vec
);
   logic [31:0] pfn_r [NUM_Q];
   logic [15:0] vec_w [NUM_Q];

   for (genvar g = 0; g < NUM_Q; g++) begin : g_q
      logic hit_g;
      assign hit_g = (sel == 16'(g));

      always_ff @(posedge clk) begin
         if (!rst_n || dev_reset)  pfn_r[g] <= '0;
         else if (pfn_we && hit_g) pfn_r[g] <= lane_merge(pfn_r[g], wdata, be);
      end
      assign q_base[g*QBASE_W +: QBASE_W] = {pfn_r[g], {PAGE_SHIFT{1'b0}}};

      if (MSIX_EN) begin : g_vec
         logic [15:0] vec_r;
         logic [31:0] vmerge;
         assign vmerge = lane_merge({vec_r, 16'h0}, wdata, {be[3:2], 2'b00});
         always_ff @(posedge clk) begin
            if (!rst_n || dev_reset)  vec_r <= '0;
            else if (vec_we && hit_g) vec_r <= vmerge[31:16];
         end
         assign vec_w[g] = vec_r;
      end else begin : g_novec
         assign vec_w[g] = NO_VEC;
      end
      assign q_vec[g*16 +: 16] = vec_w[g];
   end

   if (!MSIX_EN) begin : g_unused
      logic unused_vec_we;
      assign unused_vec_we = vec_we;
   end

   always_comb begin
      sel_valid = 1'b0;
      sel_pfn   = '0;
      sel_vec   = '0;
      for (int i = 0; i < NUM_Q; i++) begin
         if (sel == 16'(i)) begin
            sel_valid = 1'b1;
            sel_pfn   = pfn_r[i];
            sel_vec   = vec_w[i];
         end
      end
   end
endmodule

// File: rtl/pvreg_legacy.sv
module pvreg_legacy
   import pvreg_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          NUM_Q     = 4,
   parameter int          QSZ_LOG2  = 8,
   parameter logic [31:0] HOST_FEAT = 32'hA5C3_0F11,
   parameter bit          MSIX_EN   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [3:0]               be,
   input  logic                     wr,
   input  logic                     rd,
   input  logic [31:0]              wdata,
   output logic [31:0]              rdata,
   output logic                     dcfg_hit,
   output logic [ADDR_W-1:0]        dcfg_off,
   input  logic [31:0]              dcfg_rdata,
   output logic                     notify_vld,
   output logic [15:0]              notify_q,
   output logic [7:0]               dev_status,
   output logic [NUM_Q*QBASE_W-1:0] q_base,
   output logic [15:0]              cfg_vec,
   output logic [NUM_Q*16-1:0]      q_vec,
   input  logic                     irq_queue,
   input  logic                     irq_config,
   output logic                     intx
);
   localparam logic [15:0] QSIZE = 16'(1 << QSZ_LOG2);

   if (ADDR_W < 6 || ADDR_W > 16) begin : g_bad_addr
      $error("pvreg_legacy: ADDR_W must lie in 6..16");
   end
   if (NUM_Q < 1 || NUM_Q > 1024) begin : g_bad_q
      $error("pvreg_legacy: NUM_Q must lie in 1..1024");
   end
   if (QSZ_LOG2 < 0 || QSZ_LOG2 > 15) begin : g_bad_sz
      $error("pvreg_legacy: QSZ_LOG2 must lie in 0..15");
   end

   hit_t        hit;
   logic [31:0] gfeat_r;
   logic [15:0] qsel_r;
   logic [7:0]  status_r;
   logic [7:0]  isr;
   logic        dev_reset, status_we, isr_clr;
   logic        sel_valid;
   logic [31:0] sel_pfn;
   logic [15:0] sel_vec;
   logic [31:0] qsel_m;

   pvreg_decode #(.ADDR_W(ADDR_W), .MSIX_EN(MSIX_EN)) u_dec (
      .addr     (addr),
      .hit      (hit),
      .dcfg_off (dcfg_off)
   );

   assign status_we = wr && hit.ntfy && be[2];
   assign dev_reset = status_we && (wdata[23:16] == 8'h00);
   assign isr_clr   = rd && hit.ntfy && be[3];
   assign dcfg_hit  = (rd || wr) && hit.dcfg;

   pvreg_qbank #(.NUM_Q(NUM_Q), .MSIX_EN(MSIX_EN)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .dev_reset (dev_reset),
      .sel       (qsel_r),
      .pfn_we    (wr && hit.pfn),
      .vec_we    (wr && hit.vec),
      .be        (be),
      .wdata     (wdata),
      .sel_valid (sel_valid),
      .sel_pfn   (sel_pfn),
      .sel_vec   (sel_vec),
      .q_base    (q_base),
      .q_vec     (q_vec)
   );

   pvreg_isr u_isr (
      .clk   (clk),
      .rst_n (rst_n),
      .set_q (irq_queue),
      .set_c (irq_config),
      .clr   (isr_clr),
      .isr   (isr)
   );

   assign qsel_m = lane_merge({qsel_r, 16'h0}, wdata, {be[3:2], 2'b00});

   always_ff @(posedge clk) begin
      if (!rst_n || dev_reset) begin
         gfeat_r <= '0;
         qsel_r  <= '0;
      end else begin
         if (wr && hit.gfeat)  gfeat_r <= lane_merge(gfeat_r, wdata, be);
         if (wr && hit.qszsel) qsel_r  <= qsel_m[31:16];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_r   <= '0;
         notify_vld <= 1'b0;
         notify_q   <= '0;
      end else begin
         if (status_we) status_r <= wdata[23:16];
         notify_vld <= wr && hit.ntfy && (|be[1:0]);
         if (wr && hit.ntfy && (|be[1:0])) notify_q <= wdata[15:0];
      end
   end
   assign dev_status = status_r;

   if (MSIX_EN) begin : g_cfgvec
      logic [15:0] cvec_r;
      logic [31:0] cmerge;
      assign cmerge = lane_merge({16'h0, cvec_r}, wdata, {2'b00, be[1:0]});
      always_ff @(posedge clk) begin
         if (!rst_n || dev_reset) cvec_r <= '0;
         else if (wr && hit.vec)  cvec_r <= cmerge[15:0];
      end
      assign cfg_vec = cvec_r;
   end else begin : g_nocfgvec
      assign cfg_vec = NO_VEC;
   end

   logic [31:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (hit.dcfg)        rd_mux = dcfg_rdata;
      else if (hit.hfeat)  rd_mux = HOST_FEAT;
      else if (hit.gfeat)  rd_mux = gfeat_r;
      else if (hit.pfn)    rd_mux = sel_valid ? sel_pfn : 32'h0;
      else if (hit.qszsel) rd_mux = {qsel_r, sel_valid ? QSIZE : 16'h0};
      else if (hit.ntfy)   rd_mux = {isr, status_r, 16'h0};
      else if (hit.vec)    rd_mux = {sel_valid ? sel_vec : 16'h0, cfg_vec};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= rd_mux;
   end

   assign intx = |isr;
endmodule

// File: rtl/pvreg_legacy_chk.sv
module pvreg_legacy_chk #(
   parameter int          ADDR_W    = 8,
   parameter int          NUM_Q     = 4,
   parameter logic [31:0] HOST_FEAT = 32'h0
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   addr,
   input logic [3:0]          be,
   input logic                wr,
   input logic                rd,
   input logic [31:0]         wdata,
   input logic [31:0]         rdata,
   input logic                notify_vld,
   input logic [7:0]          dev_status,
   input logic [NUM_Q*44-1:0] q_base,
   input logic                irq_queue,
   input logic                irq_config,
   input logic                intx
);
   logic [ADDR_W-3:0] dw;
   assign dw = addr[ADDR_W-1:2];

   // R1
   host_feat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && dw == '0) |=> (rdata == HOST_FEAT));

   // R5
   notify_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      notify_vld |-> $past(wr && dw == (ADDR_W-2)'(4) && (|be[1:0])));

   // R6
   status_zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && dw == (ADDR_W-2)'(4) && be[2] && wdata[23:16] == 8'h00)
      |=> (dev_status == 8'h00 && q_base == '0));

   // R7
   queue_cause_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_queue |=> intx);

   // R8
   isr_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && dw == (ADDR_W-2)'(4) && be[3] && !irq_queue && !irq_config) |=> !intx);
endmodule

bind pvreg_legacy pvreg_legacy_chk #(
   .ADDR_W(ADDR_W), .NUM_Q(NUM_Q), .HOST_FEAT(HOST_FEAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .be(be), .wr(wr), .rd(rd),
   .wdata(wdata), .rdata(rdata), .notify_vld(notify_vld),
   .dev_status(dev_status), .q_base(q_base), .irq_queue(irq_queue),
   .irq_config(irq_config), .intx(intx)
);

// File: tb/tb_pvreg_legacy.sv
`timescale 1ns/1ps
module tb_pvreg_legacy;
   localparam int          AW   = 8;
   localparam int          NQ   = 4;
   localparam int          SZL  = 8;
   localparam logic [31:0] HF   = 32'hA5C3_0F11;

   logic clk = 0;
   always #5 clk = ~clk;

   logic          rst_n = 0;
   logic [AW-1:0] addr = 0;
   logic [3:0]    be = 0;
   logic          wr = 0, rd = 0;
   logic [31:0]   wdata = 0, dcfg_rdata = 32'hD0C0_FFEE;
   logic          irq_queue = 0, irq_config = 0;

   logic [31:0]   rdata, rdata_l;
   logic          dcfg_hit, dcfg_hit_l;
   logic [AW-1:0] dcfg_off, dcfg_off_l;
   logic          notify_vld, notify_vld_l;
   logic [15:0]   notify_q, notify_q_l;
   logic [7:0]    dev_status, dev_status_l;
   logic [NQ*44-1:0] q_base, q_base_l;
   logic [15:0]   cfg_vec, cfg_vec_l;
   logic [NQ*16-1:0] q_vec, q_vec_l;
   logic          intx, intx_l;

   pvreg_legacy #(.ADDR_W(AW), .NUM_Q(NQ), .QSZ_LOG2(SZL), .HOST_FEAT(HF), .MSIX_EN(1'b1)) dut (
      .clk, .rst_n, .addr, .be, .wr, .rd, .wdata, .rdata, .dcfg_hit, .dcfg_off,
      .dcfg_rdata, .notify_vld, .notify_q, .dev_status, .q_base, .cfg_vec, .q_vec,
      .irq_queue, .irq_config, .intx);

   pvreg_legacy #(.ADDR_W(AW), .NUM_Q(NQ), .QSZ_LOG2(SZL), .HOST_FEAT(HF), .MSIX_EN(1'b0)) dut_leg (
      .clk, .rst_n, .addr, .be, .wr, .rd, .wdata, .rdata(rdata_l),
      .dcfg_hit(dcfg_hit_l), .dcfg_off(dcfg_off_l), .dcfg_rdata,
      .notify_vld(notify_vld_l), .notify_q(notify_q_l), .dev_status(dev_status_l),
      .q_base(q_base_l), .cfg_vec(cfg_vec_l), .q_vec(q_vec_l),
      .irq_queue, .irq_config, .intx(intx_l));

   int n_tests = 0, n_fail = 0;
   logic          s_hit, s_hit_l, s_nv;
   logic [AW-1:0] s_off, s_off_l;
   logic [15:0]   s_nq;
   logic [31:0]   r, r_l;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // entered and left at a falling edge
   task automatic access(input bit w, input int a, input logic [3:0] b, input logic [31:0] d);
      addr = AW'(a); be = b; wdata = d; wr = w; rd = !w;
      #1;
      s_hit = dcfg_hit; s_off = dcfg_off; s_hit_l = dcfg_hit_l; s_off_l = dcfg_off_l;
      @(posedge clk); @(negedge clk);
      wr = 0; rd = 0;
      r = rdata; r_l = rdata_l; s_nv = notify_vld; s_nq = notify_q;
   endtask

   task automatic pulse(input bit q, input bit c);
      irq_queue = q; irq_config = c;
      @(posedge clk); @(negedge clk);
      irq_queue = 0; irq_config = 0;
   endtask

   function automatic logic [31:0] merge(input logic [31:0] c, input logic [31:0] n, input logic [3:0] b);
      logic [31:0] o;
      for (int l = 0; l < 4; l++) o[l*8 +: 8] = b[l] ? n[l*8 +: 8] : c[l*8 +: 8];
      return o;
   endfunction

   initial begin
      #(200000 * 10);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] exp_g;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // reset state (R2, R6, R7)
      access(0, 4, 4'hF, 0);  chk("R2 reset gfeat", r, 0);
      chk("R6 reset status", dev_status, 0);
      chk("R7 reset intx", intx, 0);

      // R1: constant host word, writes ignored
      access(0, 0, 4'hF, 0);  chk("R1 host read", r, HF);
      access(1, 0, 4'hF, 32'hFFFF_FFFF);
      access(0, 0, 4'hF, 0);  chk("R1 host after write", r, HF);

      // R2: sweep over every enable pattern
      exp_g = 0;
      for (int b = 0; b < 16; b++) begin
         logic [31:0] d;
         d = 32'h9E37_79B9 ^ (32'(b) * 32'h0101_0101);
         access(1, 4, 4'(b), d);
         exp_g = merge(exp_g, d, 4'(b));
         access(0, 4, 4'hF, 0);
         chk($sformatf("R2 gfeat be=%0d", b), r, exp_g);
      end

      // R3/R4: write every page frame, including out-of-range indices
      for (int q = 0; q < NQ + 2; q++) begin
         access(1, 12, 4'b1100, {16'(q), 16'h0});
         access(1, 8, 4'hF, 32'h1000 + 32'(q) * 32'h111);
      end
      for (int q = 0; q < NQ + 2; q++) begin
         logic [31:0] ep;
         ep = (q < NQ) ? 32'h1000 + 32'(q) * 32'h111 : 32'h0;
         access(1, 12, 4'b1100, {16'(q), 16'h0});
         access(0, 8, 4'hF, 0);
         chk($sformatf("R3 R4 pfn q=%0d", q), r, ep);
         access(0, 12, 4'hF, 0);
         chk($sformatf("R3 R4 qsel/size q=%0d", q), r, {16'(q), (q < NQ) ? 16'(1 << SZL) : 16'h0});
         if (q < NQ) chk($sformatf("R3 q_base q=%0d", q), q_base[q*44 +: 44], {ep, 12'h0});
      end

      // R5: doorbell strobes
      for (int q = 0; q < 5; q++) begin
         access(1, 16, (q % 2) ? 4'b0010 : 4'b0001, {16'h0, 16'(q * 3 + 1)});
         chk($sformatf("R5 notify vld %0d", q), s_nv, 1);
         chk($sformatf("R5 notify idx %0d", q), s_nq, 16'(q * 3 + 1));
         @(negedge clk);
         chk($sformatf("R5 notify one cycle %0d", q), notify_vld, 0);
      end
      access(1, 16, 4'b0100, 32'h0055_0007);
      chk("R5 no strobe on status-only write", s_nv, 0);
      access(0, 16, 4'b0111, 0);
      chk("R5 doorbell reads zero", r[15:0], 0);

      // R6: status store and device reset
      chk("R6 status stored", dev_status, 8'h55);
      chk("R6 status readback", r[23:16], 8'h55);
      access(1, 12, 4'b1100, 32'h0002_0000);
      access(1, 20, 4'hF, 32'h0033_0044);
      access(1, 16, 4'b0100, 32'h0);
      chk("R6 status cleared", dev_status, 0);
      chk("R6 all queue bases cleared", q_base, 0);
      chk("R6 vectors cleared", {cfg_vec, q_vec}, 0);
      access(0, 4, 4'hF, 0);  chk("R6 gfeat cleared", r, 0);
      access(0, 12, 4'hF, 0); chk("R6 qsel cleared", r[31:16], 0);

      // R7/R8: interrupt status
      pulse(1, 0);
      chk("R7 queue cause intx", intx, 1);
      access(0, 16, 4'b1000, 0); chk("R8 read value queue", r[31:24], 8'h01);
      chk("R8 cleared after read", intx, 0);
      access(0, 16, 4'b1000, 0); chk("R8 second read zero", r[31:24], 8'h00);
      pulse(0, 1);
      access(0, 16, 4'b0100, 0); chk("R8 no clear without lane 3", intx, 1);
      access(0, 16, 4'b1000, 0); chk("R7 config cause bit", r[31:24], 8'h02);
      pulse(1, 1);
      access(0, 16, 4'b1000, 0); chk("R7 both causes", r[31:24], 8'h03);
      pulse(0, 1);
      irq_queue = 1;
      access(0, 16, 4'b1000, 0);
      irq_queue = 0;
      chk("R8 value before concurrent set", r[31:24], 8'h02);
      access(0, 16, 4'b1000, 0); chk("R8 concurrent set survives", r[31:24], 8'h01);

      // R9: vectors
      access(1, 20, 4'b0011, 32'hAAAA_0012);
      access(1, 12, 4'b1100, 32'h0002_0000);
      access(1, 20, 4'b1100, 32'hFFFF_BBBB);
      access(0, 20, 4'hF, 0);
      chk("R9 vec readback", r, 32'hFFFF_0012);
      chk("R9 cfg_vec", cfg_vec, 16'h0012);
      chk("R9 q_vec q2", q_vec[2*16 +: 16], 16'hFFFF);
      chk("R9 q_vec q0 untouched", q_vec[15:0], 16'h0);
      chk("R9 legacy vectors", {cfg_vec_l, q_vec_l}, {(NQ+1){16'hFFFF}});

      // R10: device-specific base
      chk("R10 msix at 20 not dcfg", s_hit, 0);
      chk("R10 legacy at 20 dcfg", {s_hit_l, s_off_l}, {1'b1, AW'(0)});
      chk("R10 legacy read at 20", r_l, 32'hD0C0_FFEE);
      access(0, 28, 4'hF, 0);
      chk("R10 msix at 28", {s_hit, s_off}, {1'b1, AW'(4)});
      chk("R10 legacy at 28", {s_hit_l, s_off_l}, {1'b1, AW'(8)});
      chk("R10 msix read at 28", r, 32'hD0C0_FFEE);
      access(0, 16, 4'h0, 0);
      chk("R10 no dcfg below base", s_hit, 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule